// File: doc/BRIEF.md
# Serial Even-Parity Frame Inserter

This block takes a serial data stream, one bit per clock whenever a valid strobe is high, and splits it into fixed groups of four bits. Each accepted data bit is copied to the serial output in the same clock. Once the fourth bit of a group has been taken, the block uses the next clock for a parity slot. In that slot it drives a single bit chosen so that the five-bit frame (four data bits and the parity bit) holds an even number of ones. In the clock after the slot it can accept the first bit of the next group.

The controller is a nine-state machine. Its states record how many bits of the current group have been taken and whether an odd or even number of ones has been seen so far. The start state is code 0. Codes 1 to 8 pair a bit count of 1 to 4 with the running parity: count k with parity p has code 2k-1+p. The two count-4 states (codes 7 and 8) are the parity slot. Any code that is not one of the nine states returns to the start state on the next clock. While the slot is active the ready output is low and the valid strobe is ignored.

Top module: `par4_appender`

## Requirements
- R1: A synchronous active-high reset puts the machine in its start state with the running parity cleared. In the cycle after reset is released, ready is 1 and the slot flag is 0. Bits accepted before the reset do not count toward the first group after it.
- R2: When ready is 1 and the valid strobe is 1, the serial output equals the data input in that same clock.
- R3: In the clock after the fourth accepted data bit of a group, the slot flag is 1 and the serial output carries the XOR of the four data bits, so the five-bit frame has even parity.
- R4: The parity slot lasts exactly one clock.
- R5: A valid data bit presented during the parity slot is ignored. It is not counted as part of the next group and does not change that group's parity.
- R6: Ready is 0 only during the parity slot. The clock after the slot accepts a new data bit, so groups can arrive back to back.
- R7: A clock with the valid strobe low does not advance the bit count and does not change the running parity.
- R8: When no bit is being accepted and the block is not in the parity slot, the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Data bit valid strobe |
| ser_out | output | 1 | Serial output: data bits passed through, then the parity bit |
| par_slot | output | 1 | High for the one clock in which ser_out carries the parity bit |
| rdy | output | 1 | High when a data bit can be accepted |

## Verification
The hardest cases to reach are those where the strobe and the slot interact. One is a valid bit that arrives exactly in the parity slot and must not enter the next group. The other is a reset that arrives partway through a group after an odd number of ones has been seen. The bench drives a 1-bit with the strobe high during chosen slots, and then sends a group whose expected parity would be wrong if that bit had been counted. Separately, it sends a partial group with odd parity, applies reset, and checks the next full frame. Random groups are sent both back to back and with idle gaps between bits. Each frame is rebuilt from the serial output and checked for an even number of ones.

// File: rtl/par4_pkg.sv
package par4_pkg;

    localparam int GROUP_LEN  = 4;
    localparam int NUM_STATES = 2 * GROUP_LEN + 1;
    localparam int ST_W       = $clog2(NUM_STATES);
    localparam int POS_W      = $clog2(GROUP_LEN + 1);

    typedef logic [ST_W-1:0]  state_t;
    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        logic data;
        logic slot;
        logic rdy;
    } ser_port_t;

    localparam state_t ST_START = '0;

    // Bits taken so far in the current group
    function automatic pos_t st_pos(input state_t s);
        return POS_W'((32'(s) + 1) >> 1);
    endfunction

    // Running parity of the bits taken so far
    function automatic logic st_par(input state_t s);
        return (s != ST_START) && !s[0];
    endfunction

    function automatic state_t st_make(input pos_t pos, input logic par);
        if (pos == '0)
            return ST_START;
        return ST_W'(2 * 32'(pos) - 1 + 32'(par));
    endfunction

    function automatic logic st_legal(input state_t s);
        return 32'(s) < NUM_STATES;
    endfunction

    function automatic logic st_is_slot(input state_t s);
        return st_legal(s) && (32'(st_pos(s)) == GROUP_LEN);
    endfunction

endpackage

// File: rtl/par4_next.sv
module par4_next
    import par4_pkg::*;
(
    input  state_t cur,
    input  logic   bit_in,
    input  logic   bit_vld,
    output state_t nxt
);
    pos_t pos;
    logic par;

    always_comb begin
        pos = st_pos(cur);
        par = st_par(cur);
        if (!st_legal(cur))
            nxt = ST_START;                  // leave unused codes at once
        else if (st_is_slot(cur))
            nxt = ST_START;                  // slot: strobe ignored
        else if (bit_vld)
            nxt = st_make(pos + pos_t'(1), par ^ bit_in);
        else
            nxt = cur;
    end
endmodule

// File: rtl/par4_state_reg.sv
module par4_state_reg
    import par4_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_t nxt,
    output state_t cur
);
    always_ff @(posedge clk) begin
        if (rst)
            cur <= ST_START;
        else
            cur <= nxt;
    end

    // R1: reset lands on the start state
    a_r1_reset_to_start: assert property (@(posedge clk)
        rst |=> (cur == ST_START));

    // R4: slot state never repeats in consecutive cycles
    a_r4_slot_one_cycle: assert property (@(posedge clk) disable iff (rst)
        st_is_slot(cur) |=> !st_is_slot(cur));
endmodule

// File: rtl/par4_out.sv
module par4_out
    import par4_pkg::*;
(
    input  state_t    cur,
    input  logic      bit_in,
    input  logic      bit_vld,
    output ser_port_t port
);
    always_comb begin
        port.slot = st_is_slot(cur);
        port.rdy  = !port.slot;
        if (port.slot)
            port.data = st_par(cur);
        else
            port.data = bit_vld & bit_in;
    end
endmodule

// File: rtl/par4_appender.sv
module par4_appender
    import par4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_vld,
    output logic ser_out,
    output logic par_slot,
    output logic rdy
);
    state_t    cur;
    state_t    nxt;
    ser_port_t port;

    par4_next u_next (
        .cur     (cur),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .nxt     (nxt)
    );

    par4_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (cur)
    );

    par4_out u_out (
        .cur     (cur),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .port    (port)
    );

    assign ser_out  = port.data;
    assign par_slot = port.slot;
    assign rdy      = port.rdy;

    // R2: accepted bit shows on the output in the same clock
    a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
        (rdy && bit_vld) |-> (ser_out == bit_in));

    // R6: a slot is always followed by a ready cycle
    a_r6_ready_after_slot: assert property (@(posedge clk) disable iff (rst)
        par_slot |=> rdy);

    // R6: ready low implies the slot flag is up
    a_r6_ready_low_only_slot: assert property (@(posedge clk) disable iff (rst)
        !rdy |-> par_slot);

    // R8: idle output is low outside the slot
    a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
        (!bit_vld && !par_slot) |-> !ser_out);
endmodule

// File: tb/par4_appender_bench.sv
module par4_appender_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic ser_out, par_slot, rdy;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    par4_appender u_par4_appender (
        .clk (clk), .rst (rst), .bit_in (bit_in), .bit_vld (bit_vld),
        .ser_out (ser_out), .par_slot (par_slot), .rdy (rdy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Idle cycle: strobe low, nothing moves (R7, R8)
    task automatic idle_cycle();
        @(negedge clk);
        bit_vld = 1'b0; bit_in = 1'b1;
        #2;
        chk(rdy == 1'b1, "R7 ready during idle", rdy, 1);
        chk(par_slot == 1'b0, "R7 no slot during idle", par_slot, 0);
        chk(ser_out == 1'b0, "R8 idle output low", ser_out, 0);
    endtask

    // One frame: four data bits with optional gaps, then the parity slot
    task automatic send_frame(input logic [3:0] d, input int gap,
                              input bit vld_in_slot);
        logic [4:0] frame;
        for (int i = 0; i < 4; i++) begin
            for (int g = 0; g < gap; g++) idle_cycle();
            @(negedge clk);
            bit_vld = 1'b1; bit_in = d[i];
            #2;
            chk(rdy == 1'b1, "R6 ready for data bit", rdy, 1);
            chk(par_slot == 1'b0, "R4 slot flag low on data bit", par_slot, 0);
            chk(ser_out == d[i], "R2 data passthrough", ser_out, d[i]);
            frame[i] = ser_out;
        end
        @(negedge clk);
        bit_vld = vld_in_slot; bit_in = 1'b1;
        #2;
        chk(par_slot == 1'b1, "R3 slot after fourth bit", par_slot, 1);
        chk(rdy == 1'b0, "R6 ready low in slot", rdy, 0);
        chk(ser_out == ^d, "R3 parity bit", ser_out, ^d);
        frame[4] = ser_out;
        chk((^frame) == 1'b0, "R3 frame even", $countones(frame), 0);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1; bit_vld = 1'b0;
        @(negedge clk); rst = 1'b0;
        #2;
        chk(rdy == 1'b1, "R1 ready after reset", rdy, 1);
        chk(par_slot == 1'b0, "R1 no slot after reset", par_slot, 0);
        chk(ser_out == 1'b0, "R1 output low after reset", ser_out, 0);
    endtask

    task automatic t_reset_mid_group();
        // two bits, odd parity so far, then reset
        @(negedge clk); bit_vld = 1'b1; bit_in = 1'b1;
        @(negedge clk); bit_vld = 1'b1; bit_in = 1'b0;
        t_reset();
        send_frame(4'b0000, 0, 1'b0);   // R1: parity must be 0
    endtask

    task automatic t_slot_strobe_ignored();
        send_frame(4'b0011, 0, 1'b1);   // 1 offered during slot (R5)
        send_frame(4'b1000, 0, 1'b1);   // would be short by one if counted
        send_frame(4'b0110, 0, 1'b0);
    endtask

    task automatic t_back_to_back();
        for (int k = 0; k < 16; k++)
            send_frame(4'(k), 0, 1'b0);   // R6 all patterns back to back
    endtask

    task automatic t_random_gaps();
        for (int k = 0; k < 40; k++)
            send_frame(4'($urandom), int'($urandom % 3), 1'($urandom));
    endtask

    initial begin
        #(20 * 150000);
        n_errors++; n_checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_reset_mid_group();
        idle_cycle();
        t_slot_strobe_ignored();
        t_back_to_back();
        t_random_gaps();
        idle_cycle();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule